// File: doc/BRIEF.md
# Timer Input Capture Unit

This unit timestamps events on an external input pin. The pin is brought into the clock domain through a short synchronizer. A programmable condition is then watched on the synchronized signal. When the condition occurs, the unit copies the current value of one of two free-running 16-bit timers into its capture register and raises a sticky event flag. Software reads the value and clears the flag with a one-cycle strobe.

A 4-bit mode field selects the condition: off, every falling edge, every rising edge, every fourth rising edge, or every sixteenth rising edge. A shared 2-bit timer select picks the timer source. Several units on one chip decode the same select, so each unit is given a parameter with its unit index.

Top module: `input_capture_unit`

## Requirements
- R1: After reset, `cap_value` is 0 and `cap_flag` is 0.
- R2: With `mode_sel` = 4'b0100, a capture happens on every falling edge of `pin_in`, and rising edges cause none. The result appears after the third rising clock edge that follows the change of `pin_in`: two synchronizer flops, then the capture register.
- R3: With `mode_sel` = 4'b0101, a capture happens on every rising edge of `pin_in`.
- R4: With `mode_sel` = 4'b0110, a capture happens on every 4th rising edge of `pin_in`. With 4'b0111, a capture happens on every 16th rising edge. Edges in between are counted but cause no capture.
- R5: A capture loads the selected timer value, as present in the cycle before the capturing clock edge, into `cap_value` and sets `cap_flag`. `cap_value` changes at no other time.
- R6: `cap_flag` stays set until a cycle with `flag_clr` = 1. If a capture and `flag_clr` fall in the same cycle, the capture wins and the flag stays set.
- R7: With `mode_sel` = 4'b0000 the unit is off. `cap_flag` is 0 after the next clock edge, and no capture happens. The edge prescale count is discarded, while `cap_value` keeps its last value.
- R8: Any change of `mode_sel` restarts the prescale count, so the next capture in mode 0110 or 0111 needs 4 or 16 fresh rising edges.
- R9: The timer source follows `tmr_sel`. When `tmr_sel[1]` = 1, both units use `tmr_b`. The value 2'b01 gives `tmr_b` to unit index 2 and `tmr_a` to unit index 1. The value 2'b00 gives `tmr_a` to both units.
- R10: Mode values other than 0100, 0101, 0110 and 0111 never capture, never set the flag and leave `cap_value` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous event pin |
| mode_sel | input | 4 | Capture condition select |
| tmr_sel | input | 2 | Shared timer source select |
| tmr_a | input | 16 | First free-running timer value |
| tmr_b | input | 16 | Second free-running timer value |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| cap_value | output | 16 | Last captured timer value |
| cap_flag | output | 1 | Sticky capture event flag |

## Verification
Pulse trains of one to sixteen pulses are applied under every capture mode. Each pulse carries its own timer value, so the captured value shows which edge fired: a falling edge rather than a rising one, or the 4th edge rather than the 3rd or 5th. Trains one pulse short of the prescale period show that intermediate edges never capture. Two instances with unit index 1 and 2 run under all select codes, which separates the 01 encoding from the others. Directed sequences place a clear strobe on the capture cycle, change mode in the middle of a count, and apply pulses while the unit is off or in a non-capture mode.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int MODE_W    = 4;
    localparam int SEL_W     = 2;
    localparam int DIV_SHORT = 4;
    localparam int DIV_LONG  = 16;
    localparam int PER_W     = $clog2(DIV_LONG) + 1;
    localparam int CNT_W     = $clog2(DIV_LONG);

    localparam logic [MODE_W-1:0] MODE_OFF    = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_FALL   = 4'b0100;
    localparam logic [MODE_W-1:0] MODE_RISE   = 4'b0101;
    localparam logic [MODE_W-1:0] MODE_RISE4  = 4'b0110;
    localparam logic [MODE_W-1:0] MODE_RISE16 = 4'b0111;

    typedef enum logic [1:0] {
        TRIG_NONE,
        TRIG_FALL,
        TRIG_RISE,
        TRIG_RISE_DIV
    } trig_e;

    typedef struct packed {
        logic             off;
        trig_e            kind;
        logic [PER_W-1:0] period;
    } mode_dec_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_t;

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
        mode_dec_t d;
        d.off    = (m == MODE_OFF);
        d.kind   = TRIG_NONE;
        d.period = PER_W'(1);
        case (m)
            MODE_FALL:   d.kind = TRIG_FALL;
            MODE_RISE:   d.kind = TRIG_RISE;
            MODE_RISE4: begin
                d.kind   = TRIG_RISE_DIV;
                d.period = PER_W'(DIV_SHORT);
            end
            MODE_RISE16: begin
                d.kind   = TRIG_RISE_DIV;
                d.period = PER_W'(DIV_LONG);
            end
            default:     d.kind = TRIG_NONE;
        endcase
        return d;
    endfunction

    function automatic logic is_capture_mode(input logic [MODE_W-1:0] m);
        return (m == MODE_FALL) || (m == MODE_RISE) ||
               (m == MODE_RISE4) || (m == MODE_RISE16);
    endfunction

endpackage

// File: rtl/icu_sync_edge.sv
module icu_sync_edge
    import icu_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_in,
    output edge_t edges
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        edges.level = sync_q[STAGES-1];
        edges.rise  = sync_q[STAGES-1] & ~prev_q;
        edges.fall  = ~sync_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/icu_trigger.sv
module icu_trigger
    import icu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  mode_dec_t dec,
    input  edge_t     edges,
    output logic      fire
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = ({{(PER_W-CNT_W){1'b0}}, cnt_q} == (dec.period - PER_W'(1)));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (dec.kind == TRIG_RISE_DIV && edges.rise) begin
            cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        case (dec.kind)
            TRIG_FALL:     fire = edges.fall;
            TRIG_RISE:     fire = edges.rise;
            TRIG_RISE_DIV: fire = edges.rise & at_last & ~restart;
            default:       fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/icu_src_mux.sv
module icu_src_mux
    import icu_pkg::*;
#(
    parameter int UNIT_IDX = 1,
    parameter int TMR_W    = 16
) (
    input  logic [SEL_W-1:0] tmr_sel,
    input  logic [TMR_W-1:0] tmr_a,
    input  logic [TMR_W-1:0] tmr_b,
    output logic [TMR_W-1:0] src_val
);

    logic take_b;

    generate
        if (UNIT_IDX == 2) begin : g_second
            assign take_b = (tmr_sel != 2'b00);
        end else begin : g_first
            assign take_b = tmr_sel[1];
        end
    endgenerate

    assign src_val = take_b ? tmr_b : tmr_a;

endmodule

// File: rtl/input_capture_unit.sv
module input_capture_unit
    import icu_pkg::*;
#(
    parameter int UNIT_IDX    = 1,
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_in,
    input  logic [3:0]       mode_sel,
    input  logic [1:0]       tmr_sel,
    input  logic [TMR_W-1:0] tmr_a,
    input  logic [TMR_W-1:0] tmr_b,
    input  logic             flag_clr,
    output logic [TMR_W-1:0] cap_value,
    output logic             cap_flag
);

    mode_dec_t         dec;
    logic [MODE_W-1:0] mode_q;
    logic              restart;
    edge_t             edges;
    logic              fire;
    logic [TMR_W-1:0]  src_val;
    logic [TMR_W-1:0]  value_q;
    logic              flag_q;

    assign dec     = decode_mode(mode_sel);
    assign restart = dec.off | (mode_sel != mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_OFF;
        else     mode_q <= mode_sel;
    end

    icu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .edges  (edges)
    );

    icu_trigger u_trig (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .dec     (dec),
        .edges   (edges),
        .fire    (fire)
    );

    icu_src_mux #(.UNIT_IDX(UNIT_IDX), .TMR_W(TMR_W)) u_mux (
        .tmr_sel (tmr_sel),
        .tmr_a   (tmr_a),
        .tmr_b   (tmr_b),
        .src_val (src_val)
    );

    always_ff @(posedge clk) begin
        if (rst)       value_q <= '0;
        else if (fire) value_q <= src_val;
    end

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (dec.off)  flag_q <= 1'b0;
        else if (fire)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign cap_value = value_q;
    assign cap_flag  = flag_q;

endmodule

// File: rtl/icu_checker.sv
module icu_checker
    import icu_pkg::*;
#(
    parameter int UNIT_IDX = 1,
    parameter int TMR_W    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       mode_sel,
    input logic [1:0]       tmr_sel,
    input logic [TMR_W-1:0] tmr_a,
    input logic [TMR_W-1:0] tmr_b,
    input logic             flag_clr,
    input logic [TMR_W-1:0] cap_value,
    input logic             cap_flag
);

    logic [TMR_W-1:0] want_src;
    assign want_src = (tmr_sel[1] || (UNIT_IDX == 2 && tmr_sel == 2'b01)) ? tmr_b : tmr_a;

    AST_OFF_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        mode_sel == MODE_OFF |=> !cap_flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        cap_flag && !flag_clr && mode_sel != MODE_OFF |=> cap_flag); // R6

    AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(cap_flag) |-> ($past(flag_clr) || $past(mode_sel) == MODE_OFF)); // R6

    AST_VALUE_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_value) |-> cap_flag); // R5

    AST_SET_ONLY_CAPTURE_MODE: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_flag) |-> is_capture_mode($past(mode_sel))); // R10

    AST_SOURCE_SELECT: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_value) |-> cap_value == $past(want_src)); // R9

endmodule

bind input_capture_unit icu_checker #(.UNIT_IDX(UNIT_IDX), .TMR_W(TMR_W)) u_icu_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .tmr_sel   (tmr_sel),
    .tmr_a     (tmr_a),
    .tmr_b     (tmr_b),
    .flag_clr  (flag_clr),
    .cap_value (cap_value),
    .cap_flag  (cap_flag)
);

// File: tb/test_input_capture_unit.sv
`timescale 1ns/1ps
module test_input_capture_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_in = 1'b0;
    logic [3:0]  mode_sel = 4'b0000;
    logic [1:0]  tmr_sel = 2'b00;
    logic [15:0] tmr_a = 16'h0;
    logic [15:0] tmr_b = 16'h0;
    logic        flag_clr = 1'b0;
    logic [15:0] val1, val2;
    logic        flg1, flg2;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    input_capture_unit #(.UNIT_IDX(1)) i_input_capture_unit (
        .clk(clk), .rst(rst), .pin_in(pin_in), .mode_sel(mode_sel),
        .tmr_sel(tmr_sel), .tmr_a(tmr_a), .tmr_b(tmr_b), .flag_clr(flag_clr),
        .cap_value(val1), .cap_flag(flg1)
    );

    input_capture_unit #(.UNIT_IDX(2)) i_input_capture_unit_u2 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .mode_sel(mode_sel),
        .tmr_sel(tmr_sel), .tmr_a(tmr_a), .tmr_b(tmr_b), .flag_clr(flag_clr),
        .cap_value(val2), .cap_flag(flg2)
    );

    typedef struct packed {
        logic [3:0]  mode;
        logic [1:0]  sel;
        logic [4:0]  pulses;
        logic [15:0] base;
        logic        hit;
        logic [4:0]  ofs;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'b0101, 2'b00, 5'd1,  16'h1000, 1'b1, 5'd0},
        '{4'b0100, 2'b00, 5'd2,  16'h2000, 1'b1, 5'd1},
        '{4'b0110, 2'b00, 5'd5,  16'h3000, 1'b1, 5'd3},
        '{4'b0110, 2'b00, 5'd3,  16'h3100, 1'b0, 5'd0},
        '{4'b0111, 2'b00, 5'd16, 16'h4000, 1'b1, 5'd15},
        '{4'b0111, 2'b00, 5'd15, 16'h4100, 1'b0, 5'd0},
        '{4'b0101, 2'b10, 5'd2,  16'h5000, 1'b1, 5'd1},
        '{4'b0101, 2'b01, 5'd1,  16'h6000, 1'b1, 5'd0},
        '{4'b0010, 2'b00, 5'd3,  16'h7000, 1'b0, 5'd0},
        '{4'b1000, 2'b00, 5'd2,  16'h7100, 1'b0, 5'd0},
        '{4'b0110, 2'b11, 5'd8,  16'h8000, 1'b1, 5'd7}
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] a);
        @(negedge clk);
        tmr_a  = a;
        tmr_b  = ~a;
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic prepare(input logic [3:0] m, input logic [1:0] s);
        @(negedge clk);
        flag_clr = 1'b0;
        mode_sel = 4'b0000;
        tmr_sel  = s;
        repeat (2) @(negedge clk);
        mode_sel = m;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [15:0] exp1, exp2, raw;
        exp1 = 16'h0;
        exp2 = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(val1 == 16'h0, "R1 value", val1, 16'h0);
        check(flg1 == 1'b0, "R1 flag", {15'b0, flg1}, 16'h0);

        // table walk: R2 R3 R4 R5 R9 R10
        for (int v = 0; v < NV; v++) begin
            prepare(VECS[v].mode, VECS[v].sel);
            for (int p = 0; p < int'(VECS[v].pulses); p++)
                pulse(VECS[v].base + 16'(p));
            repeat (2) @(negedge clk);
            if (VECS[v].hit) begin
                raw  = VECS[v].base + 16'(VECS[v].ofs);
                exp1 = VECS[v].sel[1] ? ~raw : raw;
                exp2 = (VECS[v].sel != 2'b00) ? ~raw : raw;
            end
            check(val1 == exp1, "R5/R9 unit1 value", val1, exp1);
            check(val2 == exp2, "R5/R9 unit2 value", val2, exp2);
            check(flg1 == VECS[v].hit, "R4/R10 unit1 flag", {15'b0, flg1}, {15'b0, VECS[v].hit});
            check(flg2 == VECS[v].hit, "R4/R10 unit2 flag", {15'b0, flg2}, {15'b0, VECS[v].hit});
        end

        // R2 falling mode: rising edge ignored, latency of three clock edges
        prepare(4'b0100, 2'b00);
        @(negedge clk);
        tmr_a = 16'hA5A5;
        pin_in = 1'b1;
        repeat (5) @(negedge clk);
        check(flg1 == 1'b0, "R2 rise ignored", {15'b0, flg1}, 16'h0);
        pin_in = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        check(flg1 == 1'b0, "R2 latency early", {15'b0, flg1}, 16'h0);
        @(posedge clk);
        #1;
        check(flg1 == 1'b1, "R2 latency flag", {15'b0, flg1}, 16'h1);
        check(val1 == 16'hA5A5, "R2 value", val1, 16'hA5A5);

        // R6 sticky, then clear and capture in the same cycle
        repeat (6) @(negedge clk);
        check(flg1 == 1'b1, "R6 sticky", {15'b0, flg1}, 16'h1);
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        tmr_a = 16'h1234;
        pin_in = 1'b0;
        repeat (2) @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(flg1 == 1'b1, "R6 capture beats clear", {15'b0, flg1}, 16'h1);
        check(val1 == 16'h1234, "R6 value", val1, 16'h1234);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(flg1 == 1'b0, "R6 clear", {15'b0, flg1}, 16'h0);

        // R3 rising then R7 off mode
        prepare(4'b0101, 2'b00);
        pulse(16'h7777);
        check(val1 == 16'h7777 && flg1, "R3 rise capture", val1, 16'h7777);
        mode_sel = 4'b0000;
        @(negedge clk);
        check(flg1 == 1'b0, "R7 off clears flag", {15'b0, flg1}, 16'h0);
        pulse(16'h8888);
        check(val1 == 16'h7777 && !flg1, "R7 off no capture", val1, 16'h7777);

        // R7 prescale count discarded by off mode
        mode_sel = 4'b0110;
        repeat (3) @(negedge clk);
        for (int p = 0; p < 3; p++) pulse(16'h9000 + 16'(p));
        mode_sel = 4'b0000;
        repeat (2) @(negedge clk);
        mode_sel = 4'b0110;
        repeat (3) @(negedge clk);
        pulse(16'h9100);
        check(flg1 == 1'b0, "R7 count discarded", {15'b0, flg1}, 16'h0);
        for (int p = 1; p < 4; p++) pulse(16'h9100 + 16'(p));
        check(flg1 && val1 == 16'h9103, "R7 fresh count", val1, 16'h9103);

        // R8 mode change restarts the count
        prepare(4'b0110, 2'b00);
        for (int p = 0; p < 2; p++) pulse(16'hB000 + 16'(p));
        mode_sel = 4'b0111;
        repeat (3) @(negedge clk);
        mode_sel = 4'b0110;
        repeat (3) @(negedge clk);
        for (int p = 2; p < 4; p++) pulse(16'hB000 + 16'(p));
        check(flg1 == 1'b0, "R8 no early capture", {15'b0, flg1}, 16'h0);
        for (int p = 4; p < 6; p++) pulse(16'hB000 + 16'(p));
        check(flg1 && val1 == 16'hB005, "R8 fourth fresh edge", val1, 16'hB005);

        // R10 non-capture mode keeps value
        prepare(4'b1111, 2'b00);
        pulse(16'hC000);
        check(!flg1 && val1 == 16'hB005, "R10 mode 1111", val1, 16'hB005);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule